// File: doc/BRIEF.md
# March C- Memory Self-Test Controller

This block runs the March C- algorithm against a single-port synchronous SRAM. It produces the addresses, operations and background data itself, so nothing needs to be stored. After a start pulse it goes through six March elements. Each cell gets all of an element's operations before the address moves on. Every read is compared one cycle later against the expected all-zeros or all-ones word. At the end the block gives a one-cycle done pulse and holds a fail flag, together with the address, element and data word of the first mismatch.

An optional retention phase runs after the sixth element. It writes all-ones to every cell, idles for a programmable time, then reads every cell back. A stop-on-fail input chooses between two behaviours: run to completion, or halt at the first mismatch. The SRAM must return read data on the clock edge that follows the read request.

Top module: `march_bist_ctrl`

## Requirements
- R1: Element order is fixed. The codes are 0 = w0, 1 = (r0,w1), 2 = (r1,w0), 3 = (r0,w1), 4 = (r1,w0), 5 = r0. Writes drive an all-zeros word for w0 and an all-ones word for w1. For a two-operation element, the write goes to the same address in the cycle after the read.
- R2: Without retention, exactly 10N operations are issued for N words, one per clock, with no gaps. The first operation comes in the cycle after start is accepted. No cycle carries an extra or missing operation.
- R3: Elements 3 and 4 step the address from N-1 down to 0. All other elements step from 0 up to N-1.
- R4: A read data word is compared in the cycle after the read. An r0 read expects all-zeros and an r1 read expects all-ones. Any difference is a failure.
- R5: The first failure latches fail_addr, fail_elem and fail_data. Later mismatches in the same run leave these fields unchanged. fail_elem uses the element codes of R1, plus 6 for the retention write and 7 for the retention read.
- R6: If stop_fail was high at start, no operation is issued in the cycle that compares the first mismatching read. done then pulses in the next cycle.
- R7: If ret_en was high at start, element 6 follows element 5 and writes all-ones ascending. Then follow wait_cycles+1 idle cycles, then element 7 reads all-ones ascending. The run then takes 12N operations.
- R8: done is high for one cycle. Without a stop, it comes two cycles after the last read was issued. fail is already valid in that cycle.
- R9: fail and its fields hold until the next accepted start. They read zero in the first operation cycle of a new run.
- R10: start is ignored while a run is busy. ret_en, stop_fail and wait_cycles are sampled only when start is accepted.
- R11: After reset, done, fail, mem_we and mem_re are low.
- R12: A read and a write never occur in the same cycle. No operation is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| ret_en | input | 1 | Append the retention phase |
| stop_fail | input | 1 | Halt at the first mismatch |
| wait_cycles | input | WAIT_W | Retention idle length minus one |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | A mismatch was seen in this run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element code of the first mismatch |
| fail_data | output | DATA_W | Data word read at the first mismatch |
| mem_addr | output | ADDR_W | SRAM address |
| mem_we | output | 1 | SRAM write strobe |
| mem_re | output | 1 | SRAM read strobe |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after mem_re |

## Verification
The bench builds the full expected operation list and its cycle numbers. It compares the list against the memory port on every clock, so each of these design errors shows up as a mismatch:
- an off-by-one sweep bound;
- a wrong direction in elements 3 and 4;
- a missing retention gap;
- a wrong pause length.

Stuck-at bits and an inversion coupling fault are injected, with the aggressor both above and below the victim. A controller that compared against the wrong cycle of read data, or that swept in only one order, would miss one of these faults or report the wrong address. A stop-on-fail run checks that the operation stream ends exactly at the compare cycle. A start pulse in the middle of a run checks that the sequence does not restart.

// File: rtl/march_pkg.sv
package march_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_PAUSE,
        ST_DRAIN
    } bist_st_t;

    // op0_rd: first op is a read; op0_val / op1_val: background bit of each op
    typedef struct packed {
        logic two;
        logic desc;
        logic op0_rd;
        logic op0_val;
        logic op1_val;
    } elem_t;

    localparam logic [2:0] ELEM_LAST_MARCH = 3'd5;
    localparam logic [2:0] ELEM_RET_WR     = 3'd6;
    localparam logic [2:0] ELEM_RET_RD     = 3'd7;

    function automatic elem_t elem_info(input logic [2:0] e);
        elem_t r;
        case (e)
            3'd0: r = '{two: 1'b0, desc: 1'b0, op0_rd: 1'b0, op0_val: 1'b0, op1_val: 1'b0};
            3'd1: r = '{two: 1'b1, desc: 1'b0, op0_rd: 1'b1, op0_val: 1'b0, op1_val: 1'b1};
            3'd2: r = '{two: 1'b1, desc: 1'b0, op0_rd: 1'b1, op0_val: 1'b1, op1_val: 1'b0};
            3'd3: r = '{two: 1'b1, desc: 1'b1, op0_rd: 1'b1, op0_val: 1'b0, op1_val: 1'b1};
            3'd4: r = '{two: 1'b1, desc: 1'b1, op0_rd: 1'b1, op0_val: 1'b1, op1_val: 1'b0};
            3'd5: r = '{two: 1'b0, desc: 1'b0, op0_rd: 1'b1, op0_val: 1'b0, op1_val: 1'b0};
            3'd6: r = '{two: 1'b0, desc: 1'b0, op0_rd: 1'b0, op0_val: 1'b1, op1_val: 1'b0};
            3'd7: r = '{two: 1'b0, desc: 1'b0, op0_rd: 1'b1, op0_val: 1'b1, op1_val: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/march_seq.sv
module march_seq
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ret_en,
    input  logic              stop_fail,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic              miscmp,
    output logic              op_rd,
    output logic              op_wr,
    output logic [ADDR_W-1:0] op_addr,
    output logic              op_val,
    output logic [2:0]        op_elem,
    output logic              done,
    output logic              busy,
    output logic              start_acc
);
    localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

    bist_st_t          st, st_n;
    logic [2:0]        elem, elem_n;
    logic [ADDR_W-1:0] addr, addr_n;
    logic              phase, phase_n;
    logic [WAIT_W-1:0] cnt, cnt_n;
    logic              done_n;
    logic              ret_q, stop_q;
    logic [WAIT_W-1:0] wait_q;

    elem_t info, info_nx;
    logic  cur_rd, cur_val, last_op, last_addr, halt, issue;

    always_comb begin
        info      = elem_info(elem);
        info_nx   = elem_info(elem + 3'd1);
        cur_rd    = phase ? 1'b0 : info.op0_rd;
        cur_val   = phase ? info.op1_val : info.op0_val;
        last_op   = info.two ? phase : 1'b1;
        last_addr = info.desc ? (addr == '0) : (addr == ADDR_MAX);
        halt      = (st == ST_RUN) && stop_q && miscmp;
        issue     = (st == ST_RUN) && !halt;
        start_acc = (st == ST_IDLE) && start;
    end

    // next-state logic
    always_comb begin
        st_n    = st;
        elem_n  = elem;
        addr_n  = addr;
        phase_n = phase;
        cnt_n   = cnt;
        done_n  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    st_n    = ST_RUN;
                    elem_n  = '0;
                    addr_n  = '0;
                    phase_n = 1'b0;
                end
            end
            ST_RUN: begin
                if (halt) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                end else if (!last_op) begin
                    phase_n = 1'b1;
                end else begin
                    phase_n = 1'b0;
                    if (!last_addr) begin
                        addr_n = info.desc ? addr - 1'b1 : addr + 1'b1;
                    end else if ((elem == ELEM_LAST_MARCH && !ret_q) || elem == ELEM_RET_RD) begin
                        st_n = ST_DRAIN;
                    end else if (elem == ELEM_RET_WR) begin
                        st_n  = ST_PAUSE;
                        cnt_n = wait_q;
                    end else begin
                        elem_n = elem + 3'd1;
                        addr_n = info_nx.desc ? ADDR_MAX : '0;
                    end
                end
            end
            ST_PAUSE: begin
                if (cnt == '0) begin
                    st_n   = ST_RUN;
                    elem_n = ELEM_RET_RD;
                    addr_n = '0;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_DRAIN: begin
                st_n   = ST_IDLE;
                done_n = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            elem   <= '0;
            addr   <= '0;
            phase  <= 1'b0;
            cnt    <= '0;
            done   <= 1'b0;
            ret_q  <= 1'b0;
            stop_q <= 1'b0;
            wait_q <= '0;
        end else begin
            st    <= st_n;
            elem  <= elem_n;
            addr  <= addr_n;
            phase <= phase_n;
            cnt   <= cnt_n;
            done  <= done_n;
            if (start_acc) begin
                ret_q  <= ret_en;
                stop_q <= stop_fail;
                wait_q <= wait_cycles;
            end
        end
    end

    // outputs
    always_comb begin
        op_rd   = issue && cur_rd;
        op_wr   = issue && !cur_rd;
        op_addr = addr;
        op_val  = cur_val;
        op_elem = elem;
        busy    = (st != ST_IDLE);
    end

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_val,
    input  logic [2:0]        rd_elem,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              miscmp,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [2:0]        fail_elem,
    output logic [DATA_W-1:0] fail_data
);
    logic              pv;
    logic [ADDR_W-1:0] paddr;
    logic              pexp;
    logic [2:0]        pelem;

    always_comb miscmp = pv && (mem_rdata != {DATA_W{pexp}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv    <= 1'b0;
            paddr <= '0;
            pexp  <= 1'b0;
            pelem <= '0;
        end else begin
            pv    <= rd_issue;
            paddr <= rd_addr;
            pexp  <= rd_val;
            pelem <= rd_elem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_data <= '0;
        end else if (clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_data <= '0;
        end else if (miscmp && !fail) begin
            fail      <= 1'b1;
            fail_addr <= paddr;
            fail_elem <= pelem;
            fail_data <= mem_rdata;
        end
    end

endmodule

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ret_en,
    input  logic              stop_fail,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [2:0]        fail_elem,
    output logic [DATA_W-1:0] fail_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              op_rd, op_wr, op_val, miscmp, busy_w, start_acc;
    logic [ADDR_W-1:0] op_addr;
    logic [2:0]        op_elem;

    march_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ret_en(ret_en),
        .stop_fail(stop_fail), .wait_cycles(wait_cycles), .miscmp(miscmp),
        .op_rd(op_rd), .op_wr(op_wr), .op_addr(op_addr), .op_val(op_val),
        .op_elem(op_elem), .done(done), .busy(busy_w), .start_acc(start_acc)
    );

    march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clear(start_acc), .rd_issue(op_rd),
        .rd_addr(op_addr), .rd_val(op_val), .rd_elem(op_elem),
        .mem_rdata(mem_rdata), .miscmp(miscmp), .fail(fail),
        .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_data(fail_data)
    );

    always_comb begin
        mem_addr  = op_addr;
        mem_we    = op_wr;
        mem_re    = op_rd;
        mem_wdata = {DATA_W{op_val}};
    end

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [2:0]        fail_elem,
    input logic              mem_we,
    input logic              mem_re
);
    assert_one_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> (fail && $stable(fail_addr) && $stable(fail_elem)));

    assert_start_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !fail);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done));
endmodule

bind march_bist_ctrl march_bist_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_w), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem),
    .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/sim_march_bist_ctrl.sv
module sim_march_bist_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int WW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, ret_en = 1'b0, stop_fail = 1'b0;
    logic [WW-1:0] wait_cycles = '0;
    logic          done, fail, mem_we, mem_re;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [2:0]    fail_elem;
    logic [DW-1:0] fail_data, mem_wdata;
    logic [DW-1:0] rdm = '0;
    logic          mem_load = 1'b0;

    int checks = 0, errs = 0;

    always #4 clk = ~clk;

    march_bist_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ret_en(ret_en),
        .stop_fail(stop_fail), .wait_cycles(wait_cycles), .done(done),
        .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem),
        .fail_data(fail_data), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(rdm)
    );

    // fault configuration: stuck-at bit and inversion coupling (write A flips bit 0 of B)
    int sa_addr = -1, sa_bit = 0, sa_val = 0;
    int cp_a = -1, cp_b = 0;

    function automatic logic [DW-1:0] fx(input int a, input logic [DW-1:0] d);
        logic [DW-1:0] r = d;
        if (a == sa_addr) r[sa_bit] = sa_val[0];
        return r;
    endfunction

    logic [DW-1:0] dmem [N];
    always @(posedge clk) begin
        if (mem_load) begin
            for (int i = 0; i < N; i++) dmem[i] <= 8'h5A;
        end else begin
            if (mem_re) rdm <= fx(int'(mem_addr), dmem[mem_addr]);
            if (mem_we) begin
                dmem[mem_addr] <= fx(int'(mem_addr), mem_wdata);
                if (int'(mem_addr) == cp_a) dmem[cp_b] <= fx(cp_b, dmem[cp_b] ^ 8'h01);
            end
        end
    end

    // reference: op kind per element and op slot: 0 none, 1 r0, 2 r1, 3 w0, 4 w1
    function automatic int opk(input int e, input int j);
        case (e)
            0: return (j == 0) ? 3 : 0;
            1: return (j == 0) ? 1 : 4;
            2: return (j == 0) ? 2 : 3;
            3: return (j == 0) ? 1 : 4;
            4: return (j == 0) ? 2 : 3;
            5: return (j == 0) ? 1 : 0;
            6: return (j == 0) ? 4 : 0;
            default: return (j == 0) ? 2 : 0;
        endcase
    endfunction

    int q_we[$], q_addr[$], q_dat[$], q_cyc[$];
    logic [DW-1:0] rmem [N];
    bit xfail; int xaddr, xelem, xdata, xdone;

    task automatic build_ref(input bit ret, input bit stp, input int w);
        int cyc = 1; bit halted = 0; int last = 0;
        q_we.delete(); q_addr.delete(); q_dat.delete(); q_cyc.delete();
        for (int i = 0; i < N; i++) rmem[i] = 8'h5A;
        xfail = 0; xaddr = 0; xelem = 0; xdata = 0;
        for (int e = 0; e < (ret ? 8 : 6); e++) begin
            if (e == 7) cyc += w + 1;
            for (int s = 0; s < N; s++) begin
                int a = (e == 3 || e == 4) ? N - 1 - s : s;
                for (int j = 0; j < 2; j++) begin
                    int k = opk(e, j);
                    if (k != 0 && !halted) begin
                        q_we.push_back(k >= 3 ? 1 : 0);
                        q_addr.push_back(a);
                        q_dat.push_back(k == 4 ? 255 : 0);
                        q_cyc.push_back(cyc);
                        last = cyc;
                        if (k <= 2) begin
                            logic [DW-1:0] v = fx(a, rmem[a]);
                            logic [DW-1:0] ex = (k == 2) ? 8'hFF : 8'h00;
                            if (v != ex && !xfail) begin
                                xfail = 1; xaddr = a; xelem = e; xdata = int'(v);
                                if (stp) halted = 1;
                            end
                        end else begin
                            rmem[a] = fx(a, (k == 4) ? 8'hFF : 8'h00);
                            if (a == cp_a) rmem[cp_b] = fx(cp_b, rmem[cp_b] ^ 8'h01);
                        end
                        cyc++;
                    end
                end
            end
        end
        xdone = last + 2;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input bit ret, input bit stp, input int w, input bit poke,
                       input string tag, input bit want_fail);
        int c = 0; bit fin = 0;
        logic [AW-1:0] ha; logic [2:0] he;
        build_ref(ret, stp, w);
        @(negedge clk); mem_load = 1'b1;
        @(negedge clk); mem_load = 1'b0;
        start = 1'b1; ret_en = ret; stop_fail = stp; wait_cycles = WW'(w);
        while (!fin) begin
            @(negedge clk);
            c++;
            if (c == 1) begin
                start = 1'b0;
                chk(fail == 1'b0, "R9", "fail cleared by start", int'(fail), 0);
            end
            if (poke && c == 3) begin start = 1'b1; ret_en = 1'b0; wait_cycles = '0; end
            if (poke && c == 4) start = 1'b0;
            chk(!(mem_we && mem_re), "R12", "read and write together", 1, 0);
            if (mem_we || mem_re) begin
                if (q_cyc.size() == 0 || q_cyc[0] != c) begin
                    chk(0, "R2", "unexpected op at cycle", c, (q_cyc.size() != 0) ? q_cyc[0] : -1);
                end else begin
                    int ew = q_we.pop_front(); int ea = q_addr.pop_front();
                    int ed = q_dat.pop_front(); void'(q_cyc.pop_front());
                    chk(int'(mem_we) == ew, tag, "R1 op kind", int'(mem_we), ew);
                    chk(int'(mem_addr) == ea, tag, "R3 address", int'(mem_addr), ea);
                    if (ew == 1) chk(int'(mem_wdata) == ed, tag, "R1 write data", int'(mem_wdata), ed);
                end
            end else if (q_cyc.size() != 0 && q_cyc[0] == c) begin
                chk(0, "R2", "missing op at cycle", c, q_cyc[0]);
                void'(q_we.pop_front()); void'(q_addr.pop_front());
                void'(q_dat.pop_front()); void'(q_cyc.pop_front());
            end
            chk(done == (c == xdone), "R8", "done timing", int'(done), int'(c == xdone));
            if (c >= xdone || c > 50000) fin = 1;
        end
        chk(q_cyc.size() == 0, "R2", "ops left unissued", q_cyc.size(), 0);
        chk(fail == xfail, "R4", "fail flag", int'(fail), int'(xfail));
        chk(fail == want_fail, "R4", "fault detection", int'(fail), int'(want_fail));
        if (xfail) begin
            chk(int'(fail_addr) == xaddr, "R5", "fail_addr", int'(fail_addr), xaddr);
            chk(int'(fail_elem) == xelem, "R5", "fail_elem", int'(fail_elem), xelem);
            chk(int'(fail_data) == xdata, "R5", "fail_data", int'(fail_data), xdata);
        end
        ha = fail_addr; he = fail_elem;
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk(fail == xfail && fail_addr == ha && fail_elem == he, "R9", "fail held", int'(fail), int'(xfail));
        chk(!mem_we && !mem_re, "R12", "idle quiet", int'(mem_we | mem_re), 0);
    endtask

    initial begin
        #(8 * 150000);
        errs++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!done && !fail && !mem_we && !mem_re, "R11", "reset outputs",
            int'({done, fail, mem_we, mem_re}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_we && !mem_re && !done, "R12", "idle after reset", int'(mem_we | mem_re), 0);
        // clean March only, R1 R2 R3
        run(0, 0, 0, 0, "R1", 0);
        // clean with retention and a mid-run start, R7 R10
        run(1, 0, 5, 1, "R7", 0);
        run(1, 0, 0, 0, "R7", 0);
        // stuck-at-1 bit 3 at address 5, continue, R4 R5
        sa_addr = 5; sa_bit = 3; sa_val = 1;
        run(0, 0, 0, 0, "R4", 1);
        // stuck-at-0 bit 0 at address 15, stop early, R6
        sa_addr = 15; sa_bit = 0; sa_val = 0;
        run(0, 1, 0, 0, "R6", 1);
        run(1, 1, 3, 0, "R6", 1);
        sa_addr = -1;
        // coupling aggressor above victim, then below, R4 R5
        cp_a = 9; cp_b = 4;
        run(0, 0, 0, 0, "R4", 1);
        cp_a = 3; cp_b = 12;
        run(0, 1, 0, 0, "R6", 1);
        cp_a = -1;
        // clean run after failures clears fail, R9
        run(0, 0, 0, 0, "R9", 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule